// File: doc/BRIEF.md
# Register Multiplexer with Atomic Wide Registers

This block sits behind a narrow register bus and fans it out to a set of register elements. Each element owns a contiguous range of bus addresses. An element wider than the bus occupies one address per bus-width chunk, with its least significant chunk at the lowest address. Ranges are handed out back to back, in the order of the elements in the configuration list.

Wide elements see their accesses as single operations. A read of the lowest chunk strobes the element once and latches its whole value. Reads of the higher chunks are then served from that latched copy. Writes to the lower chunks only fill a holding buffer. The element is strobed once, with the complete new value, when the most significant chunk is written. Elements no wider than the bus are strobed directly, with no buffering.

Top module: `csr_atomic_mux`

## Requirements
- R1: Element i starts at the sum of the chunk counts of elements 0..i-1. With the default list of 1, 2 and 4 chunks, element 0 is at address 0, element 1 at 1..2 and element 2 at 3..6. No more than one element is strobed in any cycle.
- R2: A single-chunk element is strobed in the same cycle as the bus access. A write passes the bus data straight through, and a read returns the element's value.
- R3: A bus write to a chunk below the top chunk of a wide element produces no element write strobe, and the element keeps its value.
- R4: A bus write to the top chunk produces exactly one element write strobe in that cycle. The element write data holds the bus data in the top chunk and, in the lower chunks, the values most recently written to them.
- R5: A bus read of chunk 0 produces exactly one element read strobe in that cycle and latches the full element value.
- R6: A bus read of a higher chunk produces no element read strobe. It returns that chunk of the value latched by the last chunk-0 read, even if the element has changed since.
- R7: Read data is registered: it is valid in the cycle after the read strobe, and it is zero in the cycle after any cycle without a read strobe.
- R8: An access to an address outside every element range produces no element strobe, and a read of it returns zero.
- R9: Each wide element has separate read and write buffers. Reads and writes to the same element may be interleaved without disturbing each other.
- R10: Writing only the middle chunks of a wide element, without its top chunk, does not update the element.
- R11: After reset the read data is zero and all buffers are zero. A higher-chunk read made before any chunk-0 read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Bus chunk address |
| bus_r_stb | input | 1 | Bus read strobe |
| bus_r_data | output | DATA_W | Registered bus read data |
| bus_w_stb | input | 1 | Bus write strobe |
| bus_w_data | input | DATA_W | Bus write data |
| elem_r_stb | output | NUM_REG | Per-element read strobe |
| elem_r_data | input | TOTAL_CH*DATA_W | Element values, element i at bit base_i*DATA_W |
| elem_w_stb | output | NUM_REG | Per-element write strobe |
| elem_w_data | output | TOTAL_CH*DATA_W | Element write values, same packing as elem_r_data |

## Verification
A corrupted read buffer does not show when it goes wrong. It shows one cycle after a later higher-chunk read, as a wrong byte on the bus read data. The bench therefore compares every read result against a model that tracks its own copy of each latched value. A corrupted write buffer shows in the cycle of the next top-chunk write, as a wrong value on the element write data. A misdecoded address shows in the same cycle, as a strobe on the wrong element or an extra strobe. Because of this, the strobes and the write data are compared on every clock, not only at the end of each access.

// File: rtl/csr_mux_pkg.sv
package csr_mux_pkg;
    localparam int CNT_W    = 4;
    localparam int MAX_REGS = 16;

    typedef logic [MAX_REGS*CNT_W-1:0] chunk_list_t;

    function automatic int chunks_of(chunk_list_t list, int idx);
        return int'(list[idx*CNT_W +: CNT_W]);
    endfunction

    function automatic int base_of(chunk_list_t list, int idx);
        int sum;
        sum = 0;
        for (int j = 0; j < idx; j++) sum += chunks_of(list, j);
        return sum;
    endfunction

    function automatic int max_chunks(chunk_list_t list, int n);
        int m;
        m = 1;
        for (int j = 0; j < n; j++)
            if (chunks_of(list, j) > m) m = chunks_of(list, j);
        return m;
    endfunction
endpackage

// File: rtl/csr_mux_decode.sv
module csr_mux_decode
    import csr_mux_pkg::*;
#(
    parameter int          ADDR_W  = 10,
    parameter int          NUM_REG = 3,
    parameter int          IDX_W   = 2,
    parameter chunk_list_t LIST    = chunk_list_t'(12'h421)
) (
    input  logic [ADDR_W-1:0]        addr,
    output logic [NUM_REG-1:0]       hit,
    output logic [NUM_REG*IDX_W-1:0] idx
);
    for (genvar i = 0; i < NUM_REG; i++) begin : g_range
        localparam int BASE = base_of(LIST, i);
        localparam int CH   = chunks_of(LIST, i);
        logic [ADDR_W:0] addr_x;

        always_comb begin
            addr_x = {1'b0, addr};
            hit[i] = (addr_x >= (ADDR_W+1)'(BASE)) && (addr_x < (ADDR_W+1)'(BASE + CH));
            idx[i*IDX_W +: IDX_W] = IDX_W'(addr - ADDR_W'(BASE));
        end
    end
endmodule

// File: rtl/csr_mux_wide.sv
module csr_mux_wide #(
    parameter int DATA_W = 8,
    parameter int CH     = 2,
    parameter int IDX_W  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel,
    input  logic [IDX_W-1:0]     idx,
    input  logic                 bus_r_stb,
    input  logic                 bus_w_stb,
    input  logic [DATA_W-1:0]    bus_w_data,
    input  logic [CH*DATA_W-1:0] el_r_data,
    output logic                 el_r_stb,
    output logic                 el_w_stb,
    output logic [CH*DATA_W-1:0] el_w_data,
    output logic [DATA_W-1:0]    rd_byte
);
    localparam int LOW_W = (CH - 1) * DATA_W;

    typedef struct packed {
        logic [LOW_W-1:0] rd_sh;
        logic [LOW_W-1:0] wr_sh;
    } wide_state_t;

    wide_state_t state_d, state_q;
    logic        first_hit, last_hit;

    always_comb begin
        state_d   = state_q;
        first_hit = sel && (idx == '0);
        last_hit  = sel && (idx == IDX_W'(CH - 1));

        el_r_stb = bus_r_stb && first_hit;
        if (el_r_stb)
            state_d.rd_sh = el_r_data[CH*DATA_W-1:DATA_W];

        el_w_stb  = bus_w_stb && last_hit;
        el_w_data = {bus_w_data, state_q.wr_sh};
        if (bus_w_stb && sel && !last_hit) begin
            for (int k = 0; k < CH - 1; k++)
                if (idx == IDX_W'(k))
                    state_d.wr_sh[k*DATA_W +: DATA_W] = bus_w_data;
        end

        rd_byte = '0;
        if (idx == '0) begin
            rd_byte = el_r_data[DATA_W-1:0];
        end else begin
            for (int k = 1; k < CH; k++)
                if (idx == IDX_W'(k))
                    rd_byte = state_q.rd_sh[(k-1)*DATA_W +: DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // R6: the read buffer only changes on a chunk-0 read strobe
    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !el_r_stb |=> $stable(state_q.rd_sh));

    // R5: a chunk-0 read latches the upper part of the element value
    assert_rd_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        el_r_stb |=> state_q.rd_sh == $past(el_r_data[CH*DATA_W-1:DATA_W]));

    // R3: a chunk-0 write lands in the write buffer
    assert_low_buffered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_w_stb && sel && idx == '0) |=> state_q.wr_sh[DATA_W-1:0] == $past(bus_w_data));

    // R9: the write buffer is untouched by anything but writes to this element
    assert_wr_isolated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_w_stb && sel) |=> $stable(state_q.wr_sh));
endmodule

// File: rtl/csr_atomic_mux.sv
module csr_atomic_mux
    import csr_mux_pkg::*;
#(
    parameter int                     DATA_W     = 8,
    parameter int                     ADDR_W     = 10,
    parameter int                     NUM_REG    = 3,
    parameter logic [NUM_REG*4-1:0]   REG_CHUNKS = 12'h421,
    localparam chunk_list_t           LIST       = chunk_list_t'(REG_CHUNKS),
    localparam int                    TOTAL_CH   = base_of(LIST, NUM_REG),
    localparam int                    TOTAL_W    = TOTAL_CH * DATA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_r_stb,
    output logic [DATA_W-1:0]   bus_r_data,
    input  logic                bus_w_stb,
    input  logic [DATA_W-1:0]   bus_w_data,
    output logic [NUM_REG-1:0]  elem_r_stb,
    input  logic [TOTAL_W-1:0]  elem_r_data,
    output logic [NUM_REG-1:0]  elem_w_stb,
    output logic [TOTAL_W-1:0]  elem_w_data
);
    localparam int MAX_CH = max_chunks(LIST, NUM_REG);
    localparam int IDX_W  = (MAX_CH > 1) ? $clog2(MAX_CH) : 1;

    typedef struct packed {
        logic [DATA_W-1:0] r_data;
    } top_state_t;

    top_state_t               top_d, top_q;
    logic [NUM_REG-1:0]       hit;
    logic [NUM_REG*IDX_W-1:0] idx;
    logic [DATA_W-1:0]        rd_byte [NUM_REG];

    csr_mux_decode #(
        .ADDR_W (ADDR_W),
        .NUM_REG(NUM_REG),
        .IDX_W  (IDX_W),
        .LIST   (LIST)
    ) i_decode (
        .addr(bus_addr),
        .hit (hit),
        .idx (idx)
    );

    for (genvar i = 0; i < NUM_REG; i++) begin : g_elem
        localparam int BASE = base_of(LIST, i);
        localparam int CH   = chunks_of(LIST, i);

        if (CH == 1) begin : g_direct
            logic first_hit;
            assign first_hit  = hit[i] && (idx[i*IDX_W +: IDX_W] == '0);
            assign elem_r_stb[i] = bus_r_stb && first_hit;
            assign elem_w_stb[i] = bus_w_stb && first_hit;
            assign elem_w_data[BASE*DATA_W +: DATA_W] = bus_w_data;
            assign rd_byte[i] = elem_r_data[BASE*DATA_W +: DATA_W];
        end else begin : g_wide
            csr_mux_wide #(
                .DATA_W(DATA_W),
                .CH    (CH),
                .IDX_W (IDX_W)
            ) i_wide (
                .clk       (clk),
                .rst_n     (rst_n),
                .sel       (hit[i]),
                .idx       (idx[i*IDX_W +: IDX_W]),
                .bus_r_stb (bus_r_stb),
                .bus_w_stb (bus_w_stb),
                .bus_w_data(bus_w_data),
                .el_r_data (elem_r_data[BASE*DATA_W +: CH*DATA_W]),
                .el_r_stb  (elem_r_stb[i]),
                .el_w_stb  (elem_w_stb[i]),
                .el_w_data (elem_w_data[BASE*DATA_W +: CH*DATA_W]),
                .rd_byte   (rd_byte[i])
            );
        end
    end

    always_comb begin
        top_d.r_data = '0;
        if (bus_r_stb) begin
            for (int i = 0; i < NUM_REG; i++)
                if (hit[i]) top_d.r_data = top_d.r_data | rd_byte[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign bus_r_data = top_q.r_data;

    // R1: element ranges never overlap, so at most one element is strobed
    assert_one_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(elem_r_stb) && $onehot0(elem_w_stb));

    // R8: an unmapped address strobes nothing
    assert_unmapped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit == '0) |-> (elem_r_stb == '0 && elem_w_stb == '0));

    // R8: an unmapped read returns zero
    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_r_stb && hit == '0) |=> bus_r_data == '0);

    // R7: no read strobe, no read data in the following cycle
    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_r_stb |=> bus_r_data == '0);
endmodule

// File: tb/test_csr_atomic_mux.sv
module test_csr_atomic_mux;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic        bus_r_stb = 1'b0;
    logic [7:0]  bus_r_data;
    logic        bus_w_stb = 1'b0;
    logic [7:0]  bus_w_data = '0;
    logic [2:0]  elem_r_stb;
    logic [55:0] elem_r_data;
    logic [2:0]  elem_w_stb;
    logic [55:0] elem_w_data;

    always #4 clk = ~clk;

    csr_atomic_mux i_csr_atomic_mux (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr),
        .bus_r_stb(bus_r_stb), .bus_r_data(bus_r_data),
        .bus_w_stb(bus_w_stb), .bus_w_data(bus_w_data),
        .elem_r_stb(elem_r_stb), .elem_r_data(elem_r_data),
        .elem_w_stb(elem_w_stb), .elem_w_data(elem_w_data)
    );

    // element register models
    int          n_ch   [3] = '{1, 2, 4};
    int          n_base [3] = '{0, 1, 3};
    logic [31:0] elem_val [3];
    int          r_cnt [3];
    int          w_cnt [3];
    logic        poke_en = 1'b0;
    int          poke_idx = 0;
    logic [31:0] poke_val = '0;

    assign elem_r_data = {elem_val[2], elem_val[1][15:0], elem_val[0][7:0]};

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 3; i++) begin
                elem_val[i] <= '0; r_cnt[i] <= 0; w_cnt[i] <= 0;
            end
        end else begin
            for (int i = 0; i < 3; i++) begin
                if (elem_r_stb[i]) r_cnt[i] <= r_cnt[i] + 1;
                if (elem_w_stb[i]) begin
                    w_cnt[i] <= w_cnt[i] + 1;
                    elem_val[i] <= (elem_w_data >> (8 * n_base[i])) &
                                   ((64'd1 << (8 * n_ch[i])) - 1);
                end
            end
            if (poke_en) elem_val[poke_idx] <= poke_val;
        end
    end

    // reference model
    logic [31:0] mdl_rd [3];
    logic [31:0] mdl_wr [3];
    logic [7:0]  mdl_rdata;
    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    function automatic int find_reg(logic [9:0] a);
        for (int i = 0; i < 3; i++)
            if (int'(a) >= n_base[i] && int'(a) < n_base[i] + n_ch[i]) return i;
        return -1;
    endfunction

    task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            mdl_rdata <= '0;
            for (int i = 0; i < 3; i++) begin mdl_rd[i] <= '0; mdl_wr[i] <= '0; end
        end else begin
            int ri, k;
            ri = find_reg(bus_addr);
            k  = (ri >= 0) ? int'(bus_addr) - n_base[ri] : 0;
            mdl_rdata <= '0;
            if (bus_r_stb && ri >= 0) begin
                if (k == 0) begin
                    mdl_rdata <= elem_val[ri][7:0];
                    mdl_rd[ri] <= elem_val[ri];
                end else begin
                    mdl_rdata <= 8'((mdl_rd[ri] >> (8 * k)) & 32'hFF);
                end
            end
            if (bus_w_stb && ri >= 0 && k < n_ch[ri] - 1)
                mdl_wr[ri] <= (mdl_wr[ri] & ~(32'hFF << (8 * k))) |
                              (32'(bus_w_data) << (8 * k));
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int ri, k;
            logic [2:0]  exp_r, exp_w;
            logic [31:0] exp_wd, act_wd;
            ri = find_reg(bus_addr);
            k  = (ri >= 0) ? int'(bus_addr) - n_base[ri] : 0;
            exp_r = '0; exp_w = '0;
            if (ri >= 0 && bus_r_stb && k == 0) exp_r[ri] = 1'b1;
            if (ri >= 0 && bus_w_stb && k == n_ch[ri] - 1) exp_w[ri] = 1'b1;
            check(elem_r_stb == exp_r, "R5 read strobes", 64'(elem_r_stb), 64'(exp_r));
            check(elem_w_stb == exp_w, "R3 write strobes", 64'(elem_w_stb), 64'(exp_w));
            check(bus_r_data == mdl_rdata, "R7 read data", 64'(bus_r_data), 64'(mdl_rdata));
            if (exp_w != '0) begin
                exp_wd = (mdl_wr[ri] & ((32'd1 << (8 * k)) - 1)) |
                         (32'(bus_w_data) << (8 * k));
                act_wd = 32'((elem_w_data >> (8 * n_base[ri])) &
                              ((64'd1 << (8 * n_ch[ri])) - 1));
                check(act_wd == exp_wd, "R4 write data", 64'(act_wd), 64'(exp_wd));
            end
        end
    end

    task automatic bus_write(logic [9:0] a, logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_w_data = d; bus_w_stb = 1'b1;
        @(posedge clk); #1;
        bus_w_stb = 1'b0;
    endtask

    task automatic bus_read(logic [9:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_r_stb = 1'b1;
        @(posedge clk); #1;
        bus_r_stb = 1'b0;
        d = bus_r_data;
    endtask

    task automatic poke(int idx, logic [31:0] v);
        @(posedge clk); #1;
        poke_idx = idx; poke_val = v; poke_en = 1'b1;
        @(posedge clk); #1;
        poke_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", 0, 1);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #2 check(bus_r_data == 8'h00, "R11 reset read data", 64'(bus_r_data), 0);
        bus_read(10'd5, rd);
        check(rd == 8'h00, "R11 buffer zero after reset", 64'(rd), 0);

        // R2 single-chunk element
        bus_write(10'd0, 8'h55);
        check(elem_val[0] == 32'h55 && w_cnt[0] == 1, "R2 direct write", 64'(elem_val[0]), 64'h55);
        bus_read(10'd0, rd);
        check(rd == 8'h55 && r_cnt[0] == 1, "R2 direct read", 64'(rd), 64'h55);

        // R3 then R4 on the 16-bit element; R1 address map
        bus_write(10'd1, 8'haa);
        check(elem_val[1] == 0 && w_cnt[1] == 0, "R3 lower write held", 64'(elem_val[1]), 0);
        bus_write(10'd2, 8'hbb);
        check(elem_val[1] == 32'hbbaa && w_cnt[1] == 1, "R1 R4 commit at address 2",
              64'(elem_val[1]), 64'hbbaa);
        check(elem_val[0] == 32'h55, "R1 element 0 untouched", 64'(elem_val[0]), 64'h55);

        // R5 / R6 read capture
        bus_read(10'd1, rd);
        check(rd == 8'haa && r_cnt[1] == 1, "R5 chunk 0 read", 64'(rd), 64'haa);
        poke(1, 32'h3333);
        bus_read(10'd2, rd);
        check(rd == 8'hbb, "R6 captured upper chunk", 64'(rd), 64'hbb);
        check(r_cnt[1] == 1, "R6 no new read strobe", 64'(r_cnt[1]), 1);

        // R4 on the 32-bit element
        bus_write(10'd3, 8'h11); bus_write(10'd4, 8'h22);
        bus_write(10'd5, 8'h33); bus_write(10'd6, 8'h44);
        check(elem_val[2] == 32'h44332211 && w_cnt[2] == 1, "R4 full wide write",
              64'(elem_val[2]), 64'h44332211);
        // R10 middle chunks only
        bus_write(10'd4, 8'hcc); bus_write(10'd5, 8'hbb);
        check(elem_val[2] == 32'h44332211 && w_cnt[2] == 1, "R10 partial write ignored",
              64'(elem_val[2]), 64'h44332211);
        bus_write(10'd6, 8'h99);
        check(elem_val[2] == 32'h99bbcc11, "R4 buffered lowers merged",
              64'(elem_val[2]), 64'h99bbcc11);

        bus_read(10'd3, rd); check(rd == 8'h11, "R5 wide chunk 0", 64'(rd), 64'h11);
        bus_read(10'd4, rd); check(rd == 8'hcc, "R6 wide chunk 1", 64'(rd), 64'hcc);
        bus_read(10'd5, rd); check(rd == 8'hbb, "R6 wide chunk 2", 64'(rd), 64'hbb);
        bus_read(10'd6, rd); check(rd == 8'h99, "R6 wide chunk 3", 64'(rd), 64'h99);
        check(r_cnt[2] == 1, "R6 one strobe per wide read", 64'(r_cnt[2]), 1);

        // R8 unmapped
        bus_read(10'd7, rd);   check(rd == 0, "R8 unmapped read 7", 64'(rd), 0);
        bus_read(10'h3ff, rd); check(rd == 0, "R8 unmapped read 3ff", 64'(rd), 0);
        bus_write(10'd7, 8'hee); bus_write(10'h200, 8'hee);
        check(w_cnt[0] == 1 && w_cnt[1] == 1 && w_cnt[2] == 2, "R8 unmapped write quiet",
              64'(w_cnt[0] + w_cnt[1] + w_cnt[2]), 4);
        check(elem_val[2] == 32'h99bbcc11, "R8 values unchanged", 64'(elem_val[2]), 64'h99bbcc11);

        // R9 interleaved
        bus_read(10'd3, rd);
        bus_write(10'd3, 8'h01);
        bus_read(10'd4, rd); check(rd == 8'hcc, "R9 read buffer kept", 64'(rd), 64'hcc);
        bus_write(10'd4, 8'h02); bus_write(10'd5, 8'h03);
        bus_read(10'd5, rd); check(rd == 8'hbb, "R9 read after writes", 64'(rd), 64'hbb);
        bus_write(10'd6, 8'h04);
        check(elem_val[2] == 32'h04030201, "R9 write buffer kept", 64'(elem_val[2]), 64'h04030201);

        // R7 idle cycle returns zero
        bus_read(10'd0, rd);
        @(posedge clk); #1;
        check(bus_r_data == 0, "R7 idle read data", 64'(bus_r_data), 0);

        repeat (2) @(posedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule